// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits after decode in an in-order pipeline that can issue two instructions per cycle. Each cycle it looks at the two oldest decoded instructions, the older slot and the younger slot. Each one carries a group class and a valid bit. Using fixed rules about shared execution resources, the block grants issue to none, one or both of them. Issue is strictly in order. If the younger instruction cannot go with the older one, only the older one issues. The younger one then moves up to the older slot in the following cycle.

Serializing (CO) instructions occupy both issue slots. Some of them also hold the decode stage for several cycles. Decode supplies a lock-length hint with the older instruction, for example 2 for an indirect jump or return, 5 for return-from-exception and 16 for a call. After such an instruction issues, the block holds both grants low and raises its stall output until the lock has run out.

Top module: `dual_issue_pairer`

## Requirements
- R1: Class codes are 3 bits: MT=0, EX=1, BR=2, LS=3, FE=4, CO=5. Codes 6 and 7 are treated exactly like CO.
- R2: When no lock is active, a valid older instruction is always granted. An invalid older instruction blocks both grants, even if the younger one is valid. The younger grant is never high without the older grant.
- R3: A CO instruction in either slot prevents pairing. An older CO issues alone. A younger CO is held back while the older instruction issues.
- R4: The pairs EX+EX, EX+BR and BR+BR never issue together, because they share the integer unit and the branch address unit.
- R5: The pairs BR+LS and LS+LS never issue together, because they share the branch address unit and the load-store issue resource.
- R6: Two FE instructions never issue together, because they share the first floating-point stage.
- R7: MT pairs with every non-CO class, including MT. EX+LS, EX+FE, BR+FE and LS+FE also pair.
- R8: The pairing decision is the same whichever slot holds which class.
- R9: When an older CO with lock hint h ≥ 2 is granted, stall is high and both grants are low for exactly the next h−1 cycles. Issue then resumes. A hint of 0 or 1 causes no stall.
- R10: Stall is low during and after reset. While stall is high, the slot inputs are ignored: a CO with a new hint arriving during a lock neither extends nor reloads the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| old_vld | input | 1 | Older slot holds an instruction |
| old_cls | input | 3 | Group class of the older instruction |
| old_lock | input | 5 | Decode lock length hint for an older CO instruction |
| yng_vld | input | 1 | Younger slot holds an instruction |
| yng_cls | input | 3 | Group class of the younger instruction |
| grant_old | output | 1 | Older instruction issues this cycle |
| grant_yng | output | 1 | Younger instruction issues alongside it |
| stall | output | 1 | Decode is locked by an earlier CO instruction |

## Verification
All 64 ordered class pairs are driven with both slots valid, and each pair is expected to fall into one of the conflict families. This separates a missing rule from a rule applied too widely, and it also checks that the two slot orders agree. Cases where one or both slots are invalid show whether the older slot gates the younger one. CO lock hints of 0, 1, 2, 5 and 16 check the stall window at both ends. During a lock, further CO instructions with new hints are driven to show that the lock is not reloaded.

// File: rtl/dual_issue_pairer.sv
module dual_issue_pairer #(
  parameter int CLS_W  = 3,
  parameter int LOCK_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              old_vld,
  input  logic [CLS_W-1:0]  old_cls,
  input  logic [LOCK_W-1:0] old_lock,
  input  logic              yng_vld,
  input  logic [CLS_W-1:0]  yng_cls,
  output logic              grant_old,
  output logic              grant_yng,
  output logic              stall
);
  localparam logic [CLS_W-1:0] C_MT = CLS_W'(0);
  localparam logic [CLS_W-1:0] C_EX = CLS_W'(1);
  localparam logic [CLS_W-1:0] C_BR = CLS_W'(2);
  localparam logic [CLS_W-1:0] C_LS = CLS_W'(3);
  localparam logic [CLS_W-1:0] C_FE = CLS_W'(4);
  localparam logic [CLS_W-1:0] C_CO = CLS_W'(5);
  localparam logic [LOCK_W-1:0] ONE = LOCK_W'(1);

  function automatic logic serial(input logic [CLS_W-1:0] c);
    return c >= C_CO;
  endfunction

  function automatic logic clash(input logic [CLS_W-1:0] a, input logic [CLS_W-1:0] b);
    logic int_a, int_b, br_a, br_b, ls_a, ls_b;
    int_a = (a == C_EX) || (a == C_BR);
    int_b = (b == C_EX) || (b == C_BR);
    br_a  = (a == C_BR) || (a == C_LS);
    br_b  = (b == C_BR) || (b == C_LS);
    ls_a  = (a == C_LS);
    ls_b  = (b == C_LS);
    if (a == C_MT || b == C_MT) return 1'b0;
    if (int_a && int_b) return 1'b1;
    if (br_a && br_b) return 1'b1;
    if (ls_a && ls_b) return 1'b1;
    if (a == C_FE && b == C_FE) return 1'b1;
    return 1'b0;
  endfunction

  logic [LOCK_W-1:0] lock_cnt;
  logic              locked;
  logic              pair_ok;
  logic              lock_start;

  assign locked    = lock_cnt != '0;
  assign stall     = locked;
  assign pair_ok   = !serial(old_cls) && !serial(yng_cls) && !clash(old_cls, yng_cls);
  assign grant_old = !locked && old_vld;
  assign grant_yng = grant_old && yng_vld && pair_ok;
  assign lock_start = grant_old && serial(old_cls) && (old_lock > ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lock_cnt <= '0;
    else if (locked)     lock_cnt <= lock_cnt - ONE;
    else if (lock_start) lock_cnt <= old_lock - ONE;
  end
endmodule

// File: rtl/issue_pair_checker.sv
module issue_pair_checker #(
  parameter int CLS_W  = 3,
  parameter int LOCK_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              old_vld,
  input logic [CLS_W-1:0]  old_cls,
  input logic [LOCK_W-1:0] old_lock,
  input logic              yng_vld,
  input logic [CLS_W-1:0]  yng_cls,
  input logic              grant_old,
  input logic              grant_yng,
  input logic              stall
);
  assert_yng_after_old_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_yng |-> grant_old);
  assert_old_goes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && old_vld) |-> grant_old);
  assert_co_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_yng |-> (old_cls < CLS_W'(5) && yng_cls < CLS_W'(5)));
  assert_no_ex_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    grant_yng |-> !(old_cls == CLS_W'(1) && yng_cls == CLS_W'(1)));
  assert_no_ls_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_yng |-> !(old_cls == CLS_W'(3) && yng_cls == CLS_W'(3)));
  assert_no_fe_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_yng |-> !(old_cls == CLS_W'(4) && yng_cls == CLS_W'(4)));
  assert_stall_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!grant_old && !grant_yng));
  assert_lock_begins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_old && old_cls >= CLS_W'(5) && old_lock >= LOCK_W'(2)) |=> stall);
endmodule

bind dual_issue_pairer issue_pair_checker #(.CLS_W(CLS_W), .LOCK_W(LOCK_W)) u_chk (.*);

// File: tb/tb_dual_issue_pairer.sv
module tb_dual_issue_pairer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic old_vld = 1'b0, yng_vld = 1'b0;
  logic [2:0] old_cls = '0, yng_cls = '0;
  logic [4:0] old_lock = '0;
  logic grant_old, grant_yng, stall;

  int checks = 0, fails = 0, lk = 0;
  logic [2:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  dual_issue_pairer dut (.clk(clk), .rst_n(rst_n), .old_vld(old_vld), .old_cls(old_cls),
    .old_lock(old_lock), .yng_vld(yng_vld), .yng_cls(yng_cls),
    .grant_old(grant_old), .grant_yng(grant_yng), .stall(stall));

  function automatic bit pairable(int a, int b);
    if (a >= 5 || b >= 5) return 0;
    if (a == 0 || b == 0) return 1;
    if (a == b) return 0;
    if ((a == 1 && b == 2) || (a == 2 && b == 1)) return 0;
    if ((a == 2 && b == 3) || (a == 3 && b == 2)) return 0;
    return 1;
  endfunction

  function automatic string tag_of(int a, int b);
    if (a >= 6 || b >= 6) return "R1";
    if (a == 5 || b == 5) return "R3";
    if (a == 4 && b == 4) return "R6";
    if ((a == 1 || a == 2) && (b == 1 || b == 2)) return "R4";
    if ((a == 2 || a == 3) && (b == 2 || b == 3)) return "R5";
    if (a > b) return "R8";
    return "R7";
  endfunction

  task automatic drive(bit ov, int oc, int ol, bit yv, int yc, string tag);
    bit go, gy;
    @(negedge clk);
    old_vld = ov; old_cls = 3'(oc); old_lock = 5'(ol); yng_vld = yv; yng_cls = 3'(yc);
    if (lk > 0) begin
      exp_q.push_back(3'b001);
      lk--;
    end else begin
      go = ov;
      gy = ov && yv && pairable(oc, yc);
      if (go && oc >= 5 && ol >= 2) lk = ol - 1;
      exp_q.push_back({go, gy, 1'b0});
    end
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({grant_old, grant_yng, stall} !== e) begin
          fails++;
          $display("FAIL %s: got go/gy/stall=%b expected %b", t, {grant_old, grant_yng, stall}, e);
        end
      end
    end
  end

  initial begin
    #200000000;
    fails++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    old_vld = 1'b1; old_cls = 3'd5; old_lock = 5'd16;
    repeat (2) @(negedge clk);
    #2;
    checks++;
    if (stall !== 1'b0) begin
      fails++;
      $display("FAIL R10: got stall=%b in reset expected 0", stall);
    end
    old_vld = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(0, 0, 0, 0, 0, "R10");
    drive(0, 1, 0, 1, 0, "R2");
    drive(0, 5, 9, 1, 3, "R2");
    drive(1, 1, 0, 0, 0, "R2");
    drive(1, 4, 0, 0, 4, "R2");
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        drive(1, a, (a >= 5) ? 1 : 0, 1, b, tag_of(a, b));
    drive(1, 5, 0, 1, 0, "R9");
    drive(1, 0, 0, 1, 0, "R9");
    drive(1, 5, 2, 1, 0, "R9");
    drive(1, 0, 0, 1, 0, "R9");
    drive(1, 0, 0, 1, 0, "R9");
    drive(1, 6, 5, 1, 1, "R9");
    for (int i = 0; i < 4; i++) drive(1, 5, 16, 1, 0, "R10");
    drive(1, 1, 0, 1, 3, "R10");
    drive(1, 7, 16, 0, 0, "R9");
    for (int i = 0; i < 15; i++) drive(1, 5, 3, 1, 4, "R10");
    drive(1, 2, 0, 1, 4, "R9");
    drive(1, 0, 0, 1, 1, "R7");
    drive(0, 0, 0, 0, 0, "R2");
    repeat (3) @(negedge clk);
    #4;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule